// File: doc/BRIEF.md
# PHY Event Interrupt Flag Register

This block gathers single-cycle event pulses from a PHY's link and auto-negotiation logic and holds each one in a sticky flag bit. Software reads the flags through a small register port. The read returns the pending events and also acknowledges them. A separate mask register chooses which flags may raise the level interrupt output. A flag still records its event when its mask bit is off, so software can poll masked sources.

There are seven event inputs. Input `evt_i[k]` sets flag bit k+1, so the flags occupy bits 1 to 7 of a 16-bit word. The sources in bit order are:

- page received
- parallel-detect fault
- partner acknowledge
- link down
- remote fault
- negotiation complete
- energy detect

A typical driver enables link down, negotiation complete and energy detect together, which is mask value 0x00D0. To turn off every source, it writes zero to the mask.

Top module: `phy_irq_flags`

## Requirements
- R1: While `rst_n` is low, the flags, the mask, `bus_rdata` and `irq_o` are all zero. After reset the flag register and the mask register both read back as 0x0000.
- R2: A one-cycle pulse on `evt_i[k]` sets flag bit k+1. The flag stays set until the flag register is read, whatever the mask holds.
- R3: A read is `bus_sel`=1 with `bus_wr`=0. A read of address 29 loads `bus_rdata` one clock later with the flags in bits 1 to 7. Bits 0 and 8 to 15 are always zero.
- R4: A read of address 29 clears every pending flag. The following read of address 29 returns zero unless new events arrived in between.
- R5: An event that arrives in the same cycle as a flag read is left out of that read's data. It stays pending, and the next flag read returns it.
- R6: A write to address 30 stores `bus_wdata` bits 1 to 7 as the mask. All other bits are dropped. A read of address 30 returns the mask with bits 0 and 8 to 15 zero.
- R7: `irq_o` is high exactly when some flag bit and the same mask bit are both set. It changes on the clock edge that changes the flags or the mask.
- R8: Writing zero to the mask drops `irq_o` on the next edge. Pending flags are kept.
- R9: Writes to address 29 have no effect. Reads of any address other than 29 or 30 return zero. `bus_rdata` holds its value when no read occurs.
- R10: Unmasking a flag that is already pending raises `irq_o` on the edge that completes the mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block leaves reset synchronously |
| evt_i | input | 7 | Event pulses; bit k sets flag bit k+1 |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address (29 flags, 30 mask) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, updated one cycle after a read |
| irq_o | output | 1 | Level interrupt, OR of flags ANDed with mask |

## Verification
The assertions check the following on every cycle:

- each event sets its flag, and a set flag survives until a read;
- a read clears the flags, except for events that arrive with it;
- the mask changes only on a mask write, and then to the written field;
- `irq_o` always equals the OR of the flags ANDed with the mask.

Only the bench scenarios can show the behaviour seen through the register port. This covers the exact read-data words with their zero reserved bits, and an event racing a read appearing in the next read rather than the current one. It also covers writes to the flag address being ignored, unknown addresses reading zero, and the mask returning to zero after a mid-run reset.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int REG_W     = 16;
  localparam int ADDR_W    = 5;
  localparam int NUM_SRC   = 7;
  localparam int SRC_LSB   = 1;
  localparam int FLAG_ADDR = 29;
  localparam int MASK_ADDR = 30;
  localparam int SYNC_STG  = 2;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = phy_irq_pkg::SYNC_STG
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign chain_d[s] = 1'b1;
      end else begin : g_rest
        assign chain_d[s] = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else        chain_q[s] <= chain_d[s];
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = phy_irq_pkg::NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic [NUM_SRC-1:0] flags_nxt_o
);
  logic [NUM_SRC-1:0] flags_q;
  logic [NUM_SRC-1:0] flags_d;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic keep;
      always_comb begin
        keep       = flags_q[i] & ~clr_i;
        flags_d[i] = keep | evt_i[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q[i] <= 1'b0;
        else        flags_q[i] <= flags_d[i];
      end

      // R2: a pulse always lands in its flag, even when it races a read (R5)
      p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[i] |=> flags_q[i]);
      // R2: a pending flag survives any cycle without a read
      p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[i] && !clr_i) |=> flags_q[i]);
      // R4: a read with no racing event empties the flag
      p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i[i]) |=> !flags_q[i]);
    end
  endgenerate

  assign flags_o     = flags_q;
  assign flags_nxt_o = flags_d;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NUM_SRC = phy_irq_pkg::NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wr_field_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] mask_nxt_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en_i) mask_d = wr_field_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  // R6: a mask write takes the written field
  p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> mask_q == $past(wr_field_i));
  // R9: without a mask write the mask does not move
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(mask_q));

  assign mask_o     = mask_q;
  assign mask_nxt_o = mask_d;
endmodule

// File: rtl/irq_regport.sv
module irq_regport #(
  parameter int REG_W     = phy_irq_pkg::REG_W,
  parameter int ADDR_W    = phy_irq_pkg::ADDR_W,
  parameter int NUM_SRC   = phy_irq_pkg::NUM_SRC,
  parameter int SRC_LSB   = phy_irq_pkg::SRC_LSB,
  parameter int FLAG_ADDR = phy_irq_pkg::FLAG_ADDR,
  parameter int MASK_ADDR = phy_irq_pkg::MASK_ADDR
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               flag_rd_o,
  output logic               mask_wr_o,
  output logic [NUM_SRC-1:0] mask_field_o,
  output logic [REG_W-1:0]   rdata_o
);
  import phy_irq_pkg::*;

  localparam int SRC_MSB = SRC_LSB + NUM_SRC - 1;
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

  acc_kind_e         kind;
  logic              hit_flag;
  logic              hit_mask;
  logic [REG_W-1:0]  flag_word;
  logic [REG_W-1:0]  mask_word;
  logic [REG_W-1:0]  rdata_d;
  logic [REG_W-1:0]  rdata_q;
  logic              rdata_en;

  always_comb begin
    if (!bus_sel)    kind = ACC_IDLE;
    else if (bus_wr) kind = ACC_WRITE;
    else             kind = ACC_READ;
  end

  assign hit_flag = (bus_addr == A_FLAG);
  assign hit_mask = (bus_addr == A_MASK);

  // A write to the flag address has no decode target and is dropped.
  assign flag_rd_o    = (kind == ACC_READ)  && hit_flag;
  assign mask_wr_o    = (kind == ACC_WRITE) && hit_mask;
  assign mask_field_o = bus_wdata[SRC_MSB:SRC_LSB];

  // Place the source field into a full register word; all else is zero.
  generate
    for (genvar b = 0; b < REG_W; b++) begin : g_word
      if (b >= SRC_LSB && b <= SRC_MSB) begin : g_live
        assign flag_word[b] = flags_i[b-SRC_LSB];
        assign mask_word[b] = mask_i[b-SRC_LSB];
      end else begin : g_zero
        assign flag_word[b] = 1'b0;
        assign mask_word[b] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    rdata_en = (kind == ACC_READ);
    rdata_d  = rdata_q;
    if (rdata_en) begin
      if (hit_flag)      rdata_d = flag_word;
      else if (hit_mask) rdata_d = mask_word;
      else               rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  // R3: a flag read returns the flags as they stood before the read
  p_flag_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd_o |=> rdata_q[SRC_MSB:SRC_LSB] == $past(flags_i));
  // R9: read data holds between reads
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != ACC_READ) |=> $stable(rdata_q));

  assign rdata_o = rdata_q;
endmodule

// File: rtl/phy_irq_flags.sv
module phy_irq_flags #(
  parameter int REG_W     = phy_irq_pkg::REG_W,
  parameter int ADDR_W    = phy_irq_pkg::ADDR_W,
  parameter int NUM_SRC   = phy_irq_pkg::NUM_SRC,
  parameter int SRC_LSB   = phy_irq_pkg::SRC_LSB,
  parameter int FLAG_ADDR = phy_irq_pkg::FLAG_ADDR,
  parameter int MASK_ADDR = phy_irq_pkg::MASK_ADDR,
  parameter int SYNC_STG  = phy_irq_pkg::SYNC_STG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               irq_o
);
  logic               rst_int_n;
  logic               flag_rd;
  logic               mask_wr;
  logic [NUM_SRC-1:0] mask_field;
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] flags_nxt;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] mask_nxt;
  logic               irq_d;
  logic               irq_q;

  irq_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irq_regport #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .SRC_LSB(SRC_LSB),
    .FLAG_ADDR(FLAG_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_port (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .flags_i      (flags),
    .mask_i       (mask),
    .flag_rd_o    (flag_rd),
    .mask_wr_o    (mask_wr),
    .mask_field_o (mask_field),
    .rdata_o      (bus_rdata)
  );

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .evt_i       (evt_i),
    .clr_i       (flag_rd),
    .flags_o     (flags),
    .flags_nxt_o (flags_nxt)
  );

  irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en_i    (mask_wr),
    .wr_field_i (mask_field),
    .mask_o     (mask),
    .mask_nxt_o (mask_nxt)
  );

  // Registered from next-state values so the level tracks flags and mask
  // on the same edge, without a combinational path to the pin.
  assign irq_d = |(flags_nxt & mask_nxt);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R7: the pin equals the OR of masked flags on every cycle
  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o == |(flags & mask));
  // R10: a mask write that covers a pending flag raises the pin next cycle
  p_unmask_fires_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask_wr && |(flags & mask_field) && !flag_rd) |=> irq_o);
  // R8: a zero mask write drops the pin next cycle
  p_mask_zero_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask_wr && mask_field == '0) |=> !irq_o);
endmodule

// File: tb/phy_irq_flags_test.sv
module phy_irq_flags_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic        sel;
    logic        wr;
    logic [4:0]  addr;
    logic [15:0] wdata;
    logic [6:0]  evt;
    logic [15:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 5'd0,  16'h0000, 7'b0000001, 16'h0000, 1'b0, 4'd2},  // R2 masked latch
    '{1'b1, 1'b0, 5'd29, 16'h0000, 7'b0000000, 16'h0002, 1'b0, 4'd3},  // R3 read
    '{1'b1, 1'b0, 5'd29, 16'h0000, 7'b0000000, 16'h0000, 1'b0, 4'd4},  // R4 cleared
    '{1'b0, 1'b0, 5'd0,  16'h0000, 7'b1111111, 16'h0000, 1'b0, 4'd2},  // R2 all events
    '{1'b1, 1'b0, 5'd29, 16'h0000, 7'b0000000, 16'h00FE, 1'b0, 4'd3},  // R3 reserved zero
    '{1'b1, 1'b1, 5'd30, 16'hFFFF, 7'b0000000, 16'h00FE, 1'b0, 4'd6},  // R6 write all ones
    '{1'b1, 1'b0, 5'd30, 16'h0000, 7'b0000000, 16'h00FE, 1'b0, 4'd6},  // R6 field only
    '{1'b1, 1'b1, 5'd30, 16'h00D0, 7'b0000000, 16'h00FE, 1'b0, 4'd6},  // R6 typical mask
    '{1'b0, 1'b0, 5'd0,  16'h0000, 7'b0000010, 16'h00FE, 1'b0, 4'd7},  // R7 masked src
    '{1'b0, 1'b0, 5'd0,  16'h0000, 7'b0001000, 16'h00FE, 1'b1, 4'd7},  // R7 link down
    '{1'b1, 1'b1, 5'd29, 16'hFFFF, 7'b0000000, 16'h00FE, 1'b1, 4'd9},  // R9 flag write
    '{1'b1, 1'b1, 5'd30, 16'h0000, 7'b0000000, 16'h00FE, 1'b0, 4'd8},  // R8 mask off
    '{1'b1, 1'b1, 5'd30, 16'h00D0, 7'b0000000, 16'h00FE, 1'b1, 4'd10}, // R10 unmask
    '{1'b1, 1'b0, 5'd29, 16'h0000, 7'b1000000, 16'h0014, 1'b1, 4'd5},  // R5 race
    '{1'b1, 1'b0, 5'd29, 16'h0000, 7'b0000000, 16'h0080, 1'b0, 4'd5},  // R5 kept
    '{1'b1, 1'b0, 5'd5,  16'h0000, 7'b0000000, 16'h0000, 1'b0, 4'd9},  // R9 other addr
    '{1'b0, 1'b0, 5'd0,  16'h0000, 7'b0100000, 16'h0000, 1'b1, 4'd7},  // R7 complete
    '{1'b1, 1'b0, 5'd30, 16'h0000, 7'b0000000, 16'h00D0, 1'b1, 4'd6},  // R6 readback
    '{1'b1, 1'b0, 5'd29, 16'h0000, 7'b0000000, 16'h0040, 1'b0, 4'd4}   // R4 clears irq
  };

  logic        clk;
  logic        rst_n;
  logic [6:0]  evt_i;
  logic        bus_sel;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  phy_irq_flags uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic w, input logic [4:0] a,
                       input logic [15:0] d, input logic [6:0] e);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; evt_i = e;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 5'd0, 16'h0, 7'h0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", bus_rdata, 16'h0000);
    check("R1 irq", {15'h0, irq_o}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].sel, VECS[v].wr, VECS[v].addr, VECS[v].wdata, VECS[v].evt);
      @(negedge clk);
      check($sformatf("R%0d rdata row %0d", VECS[v].req, v), bus_rdata, VECS[v].exp_rd);
      check($sformatf("R%0d irq row %0d", VECS[v].req, v), {15'h0, irq_o},
            {15'h0, VECS[v].exp_irq});
    end

    // Mask is 0x00D0 here: raise link down, then reset in the middle
    drive(1'b0, 1'b0, 5'd0, 16'h0, 7'b0001000);
    @(negedge clk);
    check("R7 irq before reset", {15'h0, irq_o}, 16'h0001);
    drive(1'b0, 1'b0, 5'd0, 16'h0, 7'h0);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async irq", {15'h0, irq_o}, 16'h0000);
    check("R1 async rdata", bus_rdata, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1'b1, 1'b0, 5'd30, 16'h0, 7'h0);
    @(negedge clk);
    check("R1 mask after reset", bus_rdata, 16'h0000);
    drive(1'b1, 1'b0, 5'd29, 16'h0, 7'h0);
    @(negedge clk);
    check("R1 flags after reset", bus_rdata, 16'h0000);
    // R2 latched while mask is zero, R10 unmask raises irq
    drive(1'b0, 1'b0, 5'd0, 16'h0, 7'b1000000);
    @(negedge clk);
    check("R2 masked no irq", {15'h0, irq_o}, 16'h0000);
    drive(1'b1, 1'b1, 5'd30, 16'h0080, 7'h0);
    @(negedge clk);
    check("R10 unmask pending", {15'h0, irq_o}, 16'h0001);
    drive(1'b0, 1'b0, 5'd0, 16'h0, 7'h0);
    @(negedge clk);

    done = 1;
    finish_run();
  end
endmodule